// File: doc/BRIEF.md
# Integer ALU with Overflow Signalling

This block is the arithmetic and logic unit of a small RISC processor core. It is purely combinational: two 32-bit operands, a 5-bit shift amount and a 4-bit operation code go in, and a 32-bit result and an overflow flag come out in the same cycle. It provides add and subtract in a trapping (signed) and a wrapping (unsigned) flavour, bitwise AND, OR and NOR, logical shifts in both directions, an arithmetic right shift, and signed and unsigned set-on-less-than.

The overflow flag is meant for the exception logic of the core. Only the trapping add and subtract ever raise it. A subtract of a constant is issued as a trapping or wrapping add with a negative, already sign-extended second operand, so no subtract-immediate code exists. Bit inversion is a NOR against an all-zero operand. Shifts act on `opA`, and the amount comes from `shAmt`; `opB` is ignored for shifts.

Operation codes on `opSel`: 0 trapping add, 1 wrapping add, 2 trapping subtract, 3 wrapping subtract, 4 AND, 5 OR, 6 NOR, 7 shift left logical, 8 shift right logical, 9 shift right arithmetic, 10 signed less-than, 11 unsigned less-than, 12 to 15 reserved.

Top module: `int_alu`

## Requirements
- R1: Codes 0 (opA+opB) and 2 (opA-opB) set `overflow` exactly when the two's-complement result does not fit in 32 bits: for add when both operands share a sign that the result lacks, for subtract when the operand signs differ and the result sign differs from opA.
- R2: Codes 1 and 3 give the same sum or difference modulo 2^32 and never set `overflow`.
- R3: When codes 0 or 2 overflow, `result` still carries the sum or difference wrapped modulo 2^32.
- R4: Code 4 gives the bitwise AND and code 5 the bitwise OR of opA and opB.
- R5: Code 6 gives the bitwise NOR of opA and opB; with opB equal to zero it yields the complement of opA.
- R6: Codes 7 and 8 shift opA left or right by `shAmt` (0 to 31), filling vacated positions with zeros and dropping bits shifted out; a shift of 0 returns opA unchanged.
- R7: Code 9 shifts opA right by `shAmt`, filling vacated high positions with copies of opA bit 31 (0xFFFFFFE7 by 4 gives 0xFFFFFFFE).
- R8: Code 10 gives 1 when opA is less than opB as two's-complement numbers and 0 otherwise, correct also where opA-opB overflows.
- R9: Code 11 gives 1 when opA is less than opB as unsigned numbers and 0 otherwise.
- R10: Every code other than 0 and 2 leaves `overflow` at 0.
- R11: Reserved codes 12 to 15 give a result of 0 and no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand; the value that shifts act on |
| opB | input | 32 | Second operand; ignored by shifts |
| shAmt | input | 5 | Shift distance, 0 to 31 |
| opSel | input | 4 | Operation code as listed above |
| result | output | 32 | Operation result |
| overflow | output | 1 | Signed overflow of a trapping add or subtract |

## Verification
Both outputs are due in the same cycle as the inputs that produce them, with no register on the path, so every result is due zero clock edges after its stimulus. The bench changes inputs on the falling clock edge and samples one nanosecond later, well before the next rising edge, so each check sees the settled response to exactly one stimulus. Boundary operands (most negative, most positive, all ones, zero, shifts of 0 and 31) sit in a fixed table, and a reference model computed with wider arithmetic checks a long stream of pseudo-random operands on every code.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_NOR  = 4'd6,
    OP_SLL  = 4'd7,
    OP_SRL  = 4'd8,
    OP_SRA  = 4'd9,
    OP_SLT  = 4'd10,
    OP_SLTU = 4'd11
  } aluOp_e;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'd0,
    UNIT_LOGIC = 2'd1,
    UNIT_SHIFT = 2'd2,
    UNIT_CMP   = 2'd3
  } unitSel_e;

  typedef enum logic [1:0] {
    LOGIC_AND = 2'd0,
    LOGIC_OR  = 2'd1,
    LOGIC_NOR = 2'd2
  } logicFn_e;

  typedef struct packed {
    logic     valid;
    unitSel_e unitSel;
    logic     subtract;
    logic     trapEn;
    logicFn_e logicFn;
    logic     shiftLeft;
    logic     shiftArith;
    logic     cmpSigned;
  } aluCtl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluCtl_t         ctl
);

  always_comb begin
    ctl = '{valid: 1'b0, unitSel: UNIT_ARITH, subtract: 1'b0, trapEn: 1'b0,
            logicFn: LOGIC_AND, shiftLeft: 1'b0, shiftArith: 1'b0,
            cmpSigned: 1'b0};
    case (opSel)
      OP_ADD: begin
        ctl.valid  = 1'b1;
        ctl.trapEn = 1'b1;
      end
      OP_ADDU: ctl.valid = 1'b1;
      OP_SUB: begin
        ctl.valid    = 1'b1;
        ctl.subtract = 1'b1;
        ctl.trapEn   = 1'b1;
      end
      OP_SUBU: begin
        ctl.valid    = 1'b1;
        ctl.subtract = 1'b1;
      end
      OP_AND: begin
        ctl.valid   = 1'b1;
        ctl.unitSel = UNIT_LOGIC;
        ctl.logicFn = LOGIC_AND;
      end
      OP_OR: begin
        ctl.valid   = 1'b1;
        ctl.unitSel = UNIT_LOGIC;
        ctl.logicFn = LOGIC_OR;
      end
      OP_NOR: begin
        ctl.valid   = 1'b1;
        ctl.unitSel = UNIT_LOGIC;
        ctl.logicFn = LOGIC_NOR;
      end
      OP_SLL: begin
        ctl.valid     = 1'b1;
        ctl.unitSel   = UNIT_SHIFT;
        ctl.shiftLeft = 1'b1;
      end
      OP_SRL: begin
        ctl.valid   = 1'b1;
        ctl.unitSel = UNIT_SHIFT;
      end
      OP_SRA: begin
        ctl.valid      = 1'b1;
        ctl.unitSel    = UNIT_SHIFT;
        ctl.shiftArith = 1'b1;
      end
      OP_SLT: begin
        ctl.valid     = 1'b1;
        ctl.unitSel   = UNIT_CMP;
        ctl.subtract  = 1'b1;
        ctl.cmpSigned = 1'b1;
      end
      OP_SLTU: begin
        ctl.valid    = 1'b1;
        ctl.unitSel  = UNIT_CMP;
        ctl.subtract = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              subtract,
  output logic [DATA_W-1:0] sum,
  output logic              carryOut,
  output logic              signedOvf
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   wide;

  always_comb begin
    bEff      = subtract ? ~b : b;
    wide      = {1'b0, a} + {1'b0, bEff} + {{DATA_W{1'b0}}, subtract};
    sum       = wide[DATA_W-1:0];
    carryOut  = wide[DATA_W];
    signedOvf = (a[MSB] == bEff[MSB]) && (sum[MSB] != a[MSB]);
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   shAmt,
  input  logic              shiftLeft,
  input  logic              shiftArith,
  output logic [DATA_W-1:0] dout
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] stage [SH_W+1];
  logic [DATA_W-1:0] revIn;
  logic [DATA_W-1:0] revOut;
  logic              fillBit;

  always_comb begin
    for (int k = 0; k < DATA_W; k++) begin
      revIn[k] = din[MSB-k];
    end
  end

  assign fillBit  = shiftArith & ~shiftLeft & din[MSB];
  assign stage[0] = shiftLeft ? revIn : din;

  for (genvar i = 0; i < SH_W; i++) begin : gStage
    localparam int STEP = 1 << i;
    assign stage[i+1] = shAmt[i] ? {{STEP{fillBit}}, stage[i][MSB:STEP]}
                                 : stage[i];
  end

  always_comb begin
    for (int k = 0; k < DATA_W; k++) begin
      revOut[k] = stage[SH_W][MSB-k];
    end
  end

  assign dout = shiftLeft ? revOut : stage[SH_W];

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SH_W-1:0]   shAmt,
  input  aluCtl_t           ctl,
  output logic [DATA_W-1:0] result,
  output logic              overflow
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sumVal;
  logic              carryOut;
  logic              addOvf;
  logic [DATA_W-1:0] shiftVal;
  logic [DATA_W-1:0] logicVal;
  logic              lessBit;

  alu_addsub #(.DATA_W(DATA_W)) uAddSub (
    .a         (opA),
    .b         (opB),
    .subtract  (ctl.subtract),
    .sum       (sumVal),
    .carryOut  (carryOut),
    .signedOvf (addOvf)
  );

  alu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) uShift (
    .din        (opA),
    .shAmt      (shAmt),
    .shiftLeft  (ctl.shiftLeft),
    .shiftArith (ctl.shiftArith),
    .dout       (shiftVal)
  );

  always_comb begin
    case (ctl.logicFn)
      LOGIC_AND: logicVal = opA & opB;
      LOGIC_OR:  logicVal = opA | opB;
      LOGIC_NOR: logicVal = ~(opA | opB);
      default:   logicVal = '0;
    endcase
  end

  // Signed: difference sign corrected by overflow. Unsigned: borrow out.
  assign lessBit = ctl.cmpSigned ? (sumVal[MSB] ^ addOvf) : ~carryOut;

  always_comb begin
    result = '0;
    if (ctl.valid) begin
      case (ctl.unitSel)
        UNIT_ARITH: result = sumVal;
        UNIT_LOGIC: result = logicVal;
        UNIT_SHIFT: result = shiftVal;
        UNIT_CMP:   result = {{(DATA_W-1){1'b0}}, lessBit};
        default:    result = '0;
      endcase
    end
  end

  assign overflow = ctl.valid & ctl.trapEn & addOvf & (ctl.unitSel == UNIT_ARITH);

endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SH_W-1:0]   shAmt,
  input  logic [OP_W-1:0]   opSel,
  output logic [DATA_W-1:0] result,
  output logic              overflow
);

  aluCtl_t ctl;

  alu_ctrl uCtrl (
    .opSel (opSel),
    .ctl   (ctl)
  );

  alu_datapath #(.DATA_W(DATA_W), .SH_W(SH_W)) uDp (
    .opA      (opA),
    .opB      (opB),
    .shAmt    (shAmt),
    .ctl      (ctl),
    .result   (result),
    .overflow (overflow)
  );

endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [SH_W-1:0]   shAmt,
  input logic [OP_W-1:0]   opSel,
  input logic [DATA_W-1:0] result,
  input logic              overflow
);

  localparam int MSB = DATA_W - 1;

  always_comb begin
    // R1
    add_ovf_chk: assert (!(opSel == OP_ADD) ||
      (overflow == ((opA[MSB] == opB[MSB]) && (result[MSB] != opA[MSB]))));
    // R1
    sub_ovf_chk: assert (!(opSel == OP_SUB) ||
      (overflow == ((opA[MSB] != opB[MSB]) && (result[MSB] != opA[MSB]))));
    // R10
    no_overflow_chk: assert (!(opSel != OP_ADD && opSel != OP_SUB) || !overflow);
    // R5
    nor_invert_chk: assert (!(opSel == OP_NOR && opB == '0) || (result == ~opA));
    // R6
    shift_zero_chk: assert (!((opSel == OP_SLL || opSel == OP_SRL || opSel == OP_SRA)
      && shAmt == '0) || (result == opA));
    // R8
    cmp_range_chk: assert (!(opSel == OP_SLT || opSel == OP_SLTU)
      || (result[MSB:1] == '0));
    // R11
    reserved_zero_chk: assert (!(opSel > OP_SLTU) || (result == '0 && !overflow));
  end

endmodule

bind int_alu int_alu_checker #(.DATA_W(DATA_W), .SH_W(SH_W)) uChk (
  .opA      (opA),
  .opB      (opB),
  .shAmt    (shAmt),
  .opSel    (opSel),
  .result   (result),
  .overflow (overflow)
);

// File: tb/sim_int_alu.sv
`timescale 1ns/1ps
module sim_int_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [4:0]  shAmt = '0;
  logic [3:0]  opSel = '0;
  logic [31:0] result;
  logic        overflow;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  int_alu u0 (
    .opA(opA), .opB(opB), .shAmt(shAmt), .opSel(opSel),
    .result(result), .overflow(overflow)
  );

  // {op[105:102], a[101:70], b[69:38], sh[37:33], res[32:1], ovf[0]}
  localparam int NVEC = 28;
  localparam logic [105:0] VEC [NVEC] = '{
    {4'd0,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b1}, // R1 R3
    {4'd0,  32'h80000000, 32'h80000000, 5'd0,  32'h00000000, 1'b1}, // R1 R3
    {4'd0,  32'h00000005, 32'hFFFFFFF6, 5'd0,  32'hFFFFFFFB, 1'b0}, // R1 add -10
    {4'd0,  32'h80000000, 32'hFFFFFFFF, 5'd0,  32'h7FFFFFFF, 1'b1}, // R1
    {4'd2,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b1}, // R1 R3
    {4'd2,  32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0,  32'h80000000, 1'b1}, // R1 R3
    {4'd2,  32'h00000003, 32'h00000005, 5'd0,  32'hFFFFFFFE, 1'b0}, // R1
    {4'd2,  32'h80000000, 32'h00000000, 5'd0,  32'h80000000, 1'b0}, // R1
    {4'd1,  32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000, 1'b0}, // R2
    {4'd1,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b0}, // R2
    {4'd3,  32'h00000000, 32'h00000001, 5'd0,  32'hFFFFFFFF, 1'b0}, // R2
    {4'd3,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b0}, // R2
    {4'd4,  32'h00003C00, 32'h00000DC0, 5'd0,  32'h00000C00, 1'b0}, // R4
    {4'd5,  32'h00003C00, 32'h00000DC0, 5'd0,  32'h00003DC0, 1'b0}, // R4
    {4'd6,  32'h00003C00, 32'h00000000, 5'd0,  32'hFFFFC3FF, 1'b0}, // R5
    {4'd7,  32'h00000002, 32'hFFFFFFFF, 5'd2,  32'h00000008, 1'b0}, // R6
    {4'd7,  32'h00000001, 32'h00000000, 5'd31, 32'h80000000, 1'b0}, // R6
    {4'd8,  32'h80000001, 32'h00000000, 5'd31, 32'h00000001, 1'b0}, // R6
    {4'd8,  32'h80000000, 32'h12345678, 5'd0,  32'h80000000, 1'b0}, // R6
    {4'd9,  32'hFFFFFFE7, 32'h00000000, 5'd4,  32'hFFFFFFFE, 1'b0}, // R7
    {4'd9,  32'h7FFFFFF0, 32'h00000000, 5'd4,  32'h07FFFFFF, 1'b0}, // R7
    {4'd10, 32'h80000000, 32'h00000001, 5'd0,  32'h00000001, 1'b0}, // R8
    {4'd10, 32'h7FFFFFFF, 32'h80000000, 5'd0,  32'h00000000, 1'b0}, // R8
    {4'd10, 32'hFFFFFFFF, 32'h00000000, 5'd0,  32'h00000001, 1'b0}, // R8
    {4'd11, 32'hFFFFFFFF, 32'h00000000, 5'd0,  32'h00000000, 1'b0}, // R9
    {4'd11, 32'h00000000, 32'hFFFFFFFF, 5'd0,  32'h00000001, 1'b0}, // R9
    {4'd11, 32'h00000005, 32'h00000005, 5'd0,  32'h00000000, 1'b0}, // R9
    {4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3,  32'h00000000, 1'b0}  // R11
  };

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0, 4'd2: return "R1/R3";
      4'd1, 4'd3: return "R2";
      4'd4, 4'd5: return "R4";
      4'd6:       return "R5";
      4'd7, 4'd8: return "R6";
      4'd9:       return "R7";
      4'd10:      return "R8";
      4'd11:      return "R9";
      default:    return "R11";
    endcase
  endfunction

  // Independent reference: 64-bit signed arithmetic and language shifts.
  function automatic logic [32:0] refModel(input logic [3:0] op, input logic [31:0] a,
                                           input logic [31:0] b, input logic [4:0] sh);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint wide;
    logic [31:0] r = '0;
    logic ov = 1'b0;
    case (op)
      4'd0: begin wide = sa + sb; r = a + b; ov = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      4'd1: r = a + b;
      4'd2: begin wide = sa - sb; r = a - b; ov = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      4'd3: r = a - b;
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = ~(a | b);
      4'd7: r = a << sh;
      4'd8: r = a >> sh;
      4'd9: r = $unsigned($signed(a) >>> sh);
      4'd10: r = {31'd0, sa < sb};
      4'd11: r = {31'd0, a < b};
      default: r = '0;
    endcase
    return {ov, r};
  endfunction

  task automatic applyCheck(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                            input logic [4:0] sh, input logic [31:0] expRes, input logic expOvf,
                            input string req);
    @(negedge clk);
    opSel = op; opA = a; opB = b; shAmt = sh;
    #1;
    testsRun++;
    if (result !== expRes) begin
      testsFailed++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d result actual=%h expected=%h",
               req, op, a, b, sh, result, expRes);
    end
    testsRun++;
    if (overflow !== expOvf) begin
      testsFailed++;
      $display("FAIL %s op=%0d a=%h b=%h overflow actual=%b expected=%b",
               (op == 4'd0 || op == 4'd2) ? req : "R10", op, a, b, overflow, expOvf);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Quiescent state: zero operands on code 0 give zero, no flag (R1)
    applyCheck(4'd0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b0, "R1");

    // Table of boundary vectors
    for (int i = 0; i < NVEC; i++) begin
      applyCheck(VEC[i][105:102], VEC[i][101:70], VEC[i][69:38], VEC[i][37:33],
                 VEC[i][32:1], VEC[i][0], reqOf(VEC[i][105:102]));
    end

    // Directed: NOR with zero inverts any operand (R5)
    applyCheck(4'd6, 32'hA5A5_0F0F, 32'h0, 5'd0, 32'h5A5A_F0F0, 1'b0, "R5");
    // Directed: opB ignored by shifts (R6)
    applyCheck(4'd7, 32'h0000_00F0, 32'hDEAD_BEEF, 5'd4, 32'h0000_0F00, 1'b0, "R6");
    // Directed: reserved codes 12..14 (R11)
    for (int c = 12; c < 15; c++) begin
      applyCheck(4'(c), 32'h7FFF_FFFF, 32'h0000_0001, 5'd1, 32'h0, 1'b0, "R11");
    end
    // Directed: wrapping ops with the trapping boundary operands (R2, R10)
    applyCheck(4'd1, 32'h8000_0000, 32'h8000_0000, 5'd0, 32'h0, 1'b0, "R2");
    applyCheck(4'd10, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 32'h1, 1'b0, "R8");

    // Pseudo-random sweep over every code against the reference model
    for (int n = 0; n < 3000; n++) begin
      logic [3:0]  op = 4'(n % 16);
      logic [31:0] a = $urandom();
      logic [31:0] b = $urandom();
      logic [4:0]  sh = 5'($urandom());
      logic [32:0] exp;
      if (n % 5 == 0) b = {a[31], b[30:0]};
      if (n % 7 == 0) a = {~b[31], a[30:0]};
      exp = refModel(op, a, b, sh);
      applyCheck(op, a, b, sh, exp[31:0], exp[32], reqOf(op));
    end

    finished = 1'b1;
    summary();
  end

  initial begin
    #200000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

endmodule